// File: doc/BRIEF.md
# Reset and Boot-Mode Sequencer

This block brings a small processor core out of reset. It synchronises a raw active-low reset. It stretches that reset long enough for a clock multiplier to lock, or for a short minimum pulse on later resets. It captures four mode straps and decodes them into a boot kind and a memory configuration. It then runs one of three start-up paths:

- a byte-wide DMA load that fills the first program-memory words,
- a wait for a host write to program-memory word 0,
- no boot at all.

The core is held in reset while master reset is active, so its stack pointers go empty, its interrupts are masked and its mode/status register is cleared. After that the core is halted until the boot path finishes. Execution then begins at address 0.

The sequencer has six states:

- `ST_HOLD`: reset is asserted.
- `ST_STRETCH`: reset is released and the stretch counter runs.
- `ST_BUSWAIT`: the block waits for the external bus request to clear.
- `ST_DMA`: the byte loader runs.
- `ST_HOST`: the block waits for the host write to word 0.
- `ST_RUN`: the core runs.

The transitions are:

- Any reset goes to `ST_HOLD`.
- `ST_HOLD` goes to `ST_STRETCH` on synchronised release.
- `ST_STRETCH` goes to `ST_BUSWAIT` when the stretch count expires.
- `ST_BUSWAIT` goes to `ST_DMA`, `ST_HOST` or `ST_RUN` once the bus is free, chosen by the boot kind.
- `ST_DMA` goes to `ST_RUN` when the loader is done.
- `ST_HOST` goes to `ST_RUN` when a host write to word 0 has been seen.

The loader has four states:

- `D_IDLE`: waits for a start pulse, then goes to `D_FETCH`.
- `D_FETCH`: requests bytes and accepts one per valid handshake. After the third byte of a word it goes to `D_STORE`.
- `D_STORE`: writes one word. It goes back to `D_FETCH`, or to `D_DONE` after the last word.
- `D_DONE`: holds until cleared.

Top module: `boot_seq_top`

## Requirements
- R1: After `por_n` has been low, the first release of `ext_rst_n` keeps `core_rst` high for at least `LOCK_CYCLES` clock cycles, and for no more than `LOCK_CYCLES`+4.
- R2: Any later reset while `por_n` stays high skips the lock wait. `core_rst` falls between `WARM_CYCLES` and `WARM_CYCLES`+4 cycles after release.
- R3: While master reset is active, `core_rst` is 1 and both `core_run` and `boot_done` are 0.
- R4: The straps are read as bit3=D, bit2=C, bit1=B, bit0=A. The codes decode as follows:
  - C,B,A = 000: byte boot with full memory.
  - C,B,A = 010: no boot with full memory.
  - C,B,A = 100: byte boot with host memory.
  - C,B,A = 101: host boot with host memory.
  - Every other code: no boot with full memory.
  - `mem_full` is 1 for full memory. `ack_pd_en` is 1 only in host memory with D=0.
- R5: A byte boot writes `BOOT_WORDS` words to `pm_addr` 0, 1, 2 and so on. Each word is built from three bytes at incrementing byte addresses starting at 0, most significant byte first. Word w is {byte[3w], byte[3w+1], byte[3w+2]}.
- R6: In a byte boot, `core_run` stays 0 until the last word has been written.
- R7: In a host boot, `core_run` stays 0 until a host write to address 0 is seen. Host writes to other addresses do not release the core.
- R8: While `bus_req` is 1 after reset, no boot starts: `bm_req` and `core_run` stay 0. Boot begins once `bus_req` returns to 0.
- R9: After boot, `core_run` and `boot_done` are 1 and `start_addr` is 0. `start_ext` is 1 only for the no-boot codes.
- R10: The straps are captured only during reset. Later changes on any strap, including C, leave the decoded outputs unchanged.
- R11: A reset during a byte boot aborts it at once: `bm_req` falls and `core_run` stays 0. The whole sequence then restarts from strap capture, with the word count back at 0.
- R12: `bm_addr` stays stable while `bm_req` is 1 and `bm_valid` is 0. A byte is accepted on a cycle with both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock |
| por_n | input | 1 | Power-on indication, active low; arms the lock wait |
| ext_rst_n | input | 1 | Raw external reset, active low |
| mode_straps | input | 4 | Mode straps {D,C,B,A} |
| bus_req | input | 1 | External bus request, defers boot |
| bm_req | output | 1 | Byte-memory read request |
| bm_addr | output | BYTE_AW | Byte-memory read address |
| bm_data | input | 8 | Byte-memory read data |
| bm_valid | input | 1 | Byte-memory data valid |
| pm_we | output | 1 | Program-memory write strobe from the loader |
| pm_addr | output | PM_AW | Program-memory write address |
| pm_wdata | output | WORD_W | Program-memory write data |
| host_we | input | 1 | Host program-memory write strobe |
| host_addr | input | PM_AW | Host program-memory write address |
| core_rst | output | 1 | Core master reset |
| core_run | output | 1 | Core run enable |
| boot_done | output | 1 | Boot complete |
| start_addr | output | PM_AW | First fetch address |
| start_ext | output | 1 | First fetch from external memory |
| mem_full | output | 1 | Full-memory configuration (0 = host) |
| ack_pd_en | output | 1 | Enable internal pull-down on host acknowledge |

## Verification
The assertions watch, on every cycle, the local rules the block must never break:

- the read address is held while a byte request waits,
- the byte address tracks the word written,
- no byte request is made while the bus is claimed,
- the captured mode is frozen outside reset,
- a host-mode release is always preceded by a seen write to word 0.

Only the bench scenarios can show the rest:

- the cycle length of the cold and warm reset stretches,
- the full decode over all sixteen strap codes,
- the contents of the loaded words,
- an abort and clean restart of a boot interrupted by reset.

// File: rtl/boot_pkg.sv
package boot_pkg;

    typedef enum logic [1:0] {
        BOOT_NONE = 2'd0,
        BOOT_BYTE = 2'd1,
        BOOT_HOST = 2'd2
    } boot_kind_t;

    typedef struct packed {
        boot_kind_t kind;
        logic       full_mem;
        logic       ack_pd;
    } boot_cfg_t;

    // straps: bit3 = D, bit2 = C, bit1 = B, bit0 = A
    function automatic boot_cfg_t decode_straps(input logic [3:0] s);
        boot_cfg_t c;
        c.kind     = BOOT_NONE;
        c.full_mem = 1'b1;
        c.ack_pd   = 1'b0;
        unique case (s[2:0])
            3'b000: c.kind = BOOT_BYTE;
            3'b010: c.kind = BOOT_NONE;
            3'b100: begin
                c.kind     = BOOT_BYTE;
                c.full_mem = 1'b0;
                c.ack_pd   = ~s[3];
            end
            3'b101: begin
                c.kind     = BOOT_HOST;
                c.full_mem = 1'b0;
                c.ack_pd   = ~s[3];
            end
            default: c.kind = BOOT_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_o
);
    logic [STAGES-1:0] shift_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) shift_q <= '0;
        else         shift_q <= {shift_q[STAGES-2:0], 1'b1};
    end

    assign rst_o = ~shift_q[STAGES-1];
endmodule

// File: rtl/host_watch.sv
module host_watch #(
    parameter int PM_AW = 14
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             arm,
    input  logic             we,
    input  logic [PM_AW-1:0] addr,
    output logic             seen
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (clr)                             seen_q <= 1'b0;
        else if (arm && we && addr == '0)    seen_q <= 1'b1;
    end

    assign seen = seen_q;
endmodule

// File: rtl/boot_dma.sv
module boot_dma #(
    parameter int WORDS   = 32,
    parameter int BYTE_AW = 16,
    parameter int PM_AW   = 14,
    parameter int WORD_W  = 24
) (
    input  logic               clk,
    input  logic               clr,
    input  logic               start,
    output logic               bm_req,
    output logic [BYTE_AW-1:0] bm_addr,
    input  logic [7:0]         bm_data,
    input  logic               bm_valid,
    output logic               pm_we,
    output logic [PM_AW-1:0]   pm_addr,
    output logic [WORD_W-1:0]  pm_wdata,
    output logic               done
);
    localparam int BPW  = WORD_W / 8;
    localparam int WI_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int BI_W = (BPW > 1) ? $clog2(BPW) : 1;

    typedef enum logic [1:0] {D_IDLE, D_FETCH, D_STORE, D_DONE} dstate_t;

    dstate_t            st_q, st_d;
    logic [WI_W-1:0]    word_q;
    logic [BI_W-1:0]    bidx_q;
    logic [BYTE_AW-1:0] baddr_q;
    logic [WORD_W-1:0]  asm_q;

    wire take     = (st_q == D_FETCH) && bm_valid;
    wire last_b   = (bidx_q == BI_W'(BPW - 1));
    wire last_w   = (word_q == WI_W'(WORDS - 1));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            D_IDLE:  if (start) st_d = D_FETCH;
            D_FETCH: if (take && last_b) st_d = D_STORE;
            D_STORE: st_d = last_w ? D_DONE : D_FETCH;
            D_DONE:  st_d = D_DONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (clr) st_q <= D_IDLE;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (clr || st_q == D_IDLE) begin
            word_q  <= '0;
            bidx_q  <= '0;
            baddr_q <= '0;
        end else begin
            if (take) begin
                asm_q   <= {asm_q[WORD_W-9:0], bm_data};
                baddr_q <= baddr_q + 1'b1;
                bidx_q  <= last_b ? '0 : bidx_q + 1'b1;
            end
            if (st_q == D_STORE && !last_w) word_q <= word_q + 1'b1;
        end
    end

    always_comb begin
        bm_req   = (st_q == D_FETCH);
        bm_addr  = baddr_q;
        pm_we    = (st_q == D_STORE);
        pm_addr  = PM_AW'(word_q);
        pm_wdata = asm_q;
        done     = (st_q == D_DONE);
    end

    // R12
    addr_hold_chk: assert property (@(posedge clk) disable iff (clr)
        (bm_req && !bm_valid) |=> $stable(bm_addr));

    // R5
    byte_addr_chk: assert property (@(posedge clk) disable iff (clr)
        pm_we |-> (int'(bm_addr) == (int'(pm_addr) + 1) * BPW));
endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
    import boot_pkg::*;
#(
    parameter int LOCK_CYCLES = 2000,
    parameter int WARM_CYCLES = 4,
    parameter int SYNC_STAGES = 2,
    parameter int BOOT_WORDS  = 32,
    parameter int BYTE_AW     = 16,
    parameter int PM_AW       = 14,
    parameter int WORD_W      = 24
) (
    input  logic               clk_in,
    input  logic               por_n,
    input  logic               ext_rst_n,
    input  logic [3:0]         mode_straps,
    input  logic               bus_req,
    output logic               bm_req,
    output logic [BYTE_AW-1:0] bm_addr,
    input  logic [7:0]         bm_data,
    input  logic               bm_valid,
    output logic               pm_we,
    output logic [PM_AW-1:0]   pm_addr,
    output logic [WORD_W-1:0]  pm_wdata,
    input  logic               host_we,
    input  logic [PM_AW-1:0]   host_addr,
    output logic               core_rst,
    output logic               core_run,
    output logic               boot_done,
    output logic [PM_AW-1:0]   start_addr,
    output logic               start_ext,
    output logic               mem_full,
    output logic               ack_pd_en
);
    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);

    typedef enum logic [2:0] {
        ST_HOLD, ST_STRETCH, ST_BUSWAIT, ST_DMA, ST_HOST, ST_RUN
    } seq_t;

    seq_t             state_q, state_d;
    logic             rst_s;
    logic             locked_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    boot_cfg_t        cfg_q;
    logic             dma_start, dma_done, host_seen;

    rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk_in), .arst_n(ext_rst_n), .rst_o(rst_s)
    );

    assign limit = locked_q ? CNT_W'(WARM_CYCLES) : CNT_W'(LOCK_CYCLES);
    wire stretch_end = (state_q == ST_STRETCH) && (cnt_q == limit - CNT_W'(1));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:    state_d = ST_STRETCH;
            ST_STRETCH: if (stretch_end) state_d = ST_BUSWAIT;
            ST_BUSWAIT: if (!bus_req) begin
                unique case (cfg_q.kind)
                    BOOT_BYTE: state_d = ST_DMA;
                    BOOT_HOST: state_d = ST_HOST;
                    default:   state_d = ST_RUN;
                endcase
            end
            ST_DMA:     if (dma_done) state_d = ST_RUN;
            ST_HOST:    if (host_seen) state_d = ST_RUN;
            ST_RUN:     state_d = ST_RUN;
            default:    state_d = ST_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk_in) begin
        if (rst_s) state_q <= ST_HOLD;
        else       state_q <= state_d;
    end

    always_ff @(posedge clk_in) begin
        if (state_q != ST_STRETCH || rst_s) cnt_q <= '0;
        else                                cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk_in or negedge por_n) begin
        if (!por_n)                     locked_q <= 1'b0;
        else if (stretch_end && !rst_s) locked_q <= 1'b1;
    end

    // strap capture only while in reset
    always_ff @(posedge clk_in) begin
        if (rst_s || state_q == ST_HOLD || state_q == ST_STRETCH)
            cfg_q <= decode_straps(mode_straps);
    end

    assign dma_start = (state_q == ST_BUSWAIT) && !bus_req && (cfg_q.kind == BOOT_BYTE);

    boot_dma #(
        .WORDS(BOOT_WORDS), .BYTE_AW(BYTE_AW), .PM_AW(PM_AW), .WORD_W(WORD_W)
    ) u_dma (
        .clk(clk_in), .clr(rst_s), .start(dma_start),
        .bm_req(bm_req), .bm_addr(bm_addr), .bm_data(bm_data), .bm_valid(bm_valid),
        .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata), .done(dma_done)
    );

    host_watch #(.PM_AW(PM_AW)) u_host (
        .clk(clk_in), .clr(rst_s), .arm(state_q == ST_HOST),
        .we(host_we), .addr(host_addr), .seen(host_seen)
    );

    // outputs
    always_comb begin
        core_rst   = (state_q == ST_HOLD) || (state_q == ST_STRETCH);
        core_run   = (state_q == ST_RUN);
        boot_done  = (state_q == ST_RUN);
        start_addr = '0;
        start_ext  = (cfg_q.kind == BOOT_NONE);
        mem_full   = cfg_q.full_mem;
        ack_pd_en  = cfg_q.ack_pd;
    end

    // R8
    bus_defer_chk: assert property (@(posedge clk_in) disable iff (rst_s)
        (state_q == ST_BUSWAIT && bus_req) |=> !bm_req);

    // R10
    straps_frozen_chk: assert property (@(posedge clk_in) disable iff (rst_s)
        (!core_rst && !$past(core_rst)) |-> $stable(cfg_q));

    // R7
    host_release_chk: assert property (@(posedge clk_in) disable iff (rst_s)
        ($past(state_q) == ST_HOST && state_q == ST_RUN) |-> $past(host_seen));

    // R6
    dma_release_chk: assert property (@(posedge clk_in) disable iff (rst_s)
        ($past(state_q) == ST_DMA && state_q == ST_RUN) |-> $past(dma_done));
endmodule

// File: tb/boot_seq_top_test.sv
module boot_seq_top_test;
    localparam int LOCK  = 2000;
    localparam int WARM  = 4;
    localparam int WORDS = 32;

    logic        clk = 1'b0;
    logic        por_n, ext_rst_n, bus_req, bm_valid, host_we;
    logic [3:0]  mode_straps;
    logic [7:0]  bm_data;
    logic [13:0] host_addr;
    logic        bm_req, pm_we, core_rst, core_run, boot_done, start_ext, mem_full, ack_pd_en;
    logic [15:0] bm_addr;
    logic [13:0] pm_addr, start_addr;
    logic [23:0] pm_wdata;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int wr_cnt = 0;
    logic [23:0] mem [WORDS];
    bit          written [WORDS];

    // kind[4:3] (0 none,1 byte,2 host), full[2], ackpd[1], ext[0]; index = strap code
    localparam logic [4:0] VEC [16] = '{
        5'b01100, 5'b00101, 5'b00101, 5'b00101,
        5'b01010, 5'b10010, 5'b00101, 5'b00101,
        5'b01100, 5'b00101, 5'b00101, 5'b00101,
        5'b01000, 5'b10000, 5'b00101, 5'b00101
    };

    boot_seq_top uut (
        .clk_in(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .mode_straps(mode_straps),
        .bus_req(bus_req), .bm_req(bm_req), .bm_addr(bm_addr), .bm_data(bm_data),
        .bm_valid(bm_valid), .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
        .host_we(host_we), .host_addr(host_addr), .core_rst(core_rst), .core_run(core_run),
        .boot_done(boot_done), .start_addr(start_addr), .start_ext(start_ext),
        .mem_full(mem_full), .ack_pd_en(ack_pd_en)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] bval(input int a);
        return 8'(a * 7 + 3) ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // byte memory responder, variable latency
    bit served = 0;
    int lat = 0;
    always @(negedge clk) begin
        if (served) begin
            bm_valid = 1'b0; served = 0; lat = 0;
        end else if (bm_req === 1'b1) begin
            if (lat >= int'(bm_addr % 4)) begin
                bm_valid = 1'b1; bm_data = bval(int'(bm_addr)); served = 1;
            end else lat++;
        end else begin
            bm_valid = 1'b0; lat = 0;
        end
    end

    // program-memory write monitor
    always @(negedge clk) begin
        if (pm_we === 1'b1) begin
            wr_cnt++;
            if (int'(pm_addr) < WORDS) begin
                mem[pm_addr] = pm_wdata;
                written[pm_addr] = 1;
            end
        end
    end

    // watchdog
    always @(negedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            finish_run();
        end
    end

    task automatic clear_mon();
        wr_cnt = 0;
        for (int i = 0; i < WORDS; i++) begin
            mem[i] = '0; written[i] = 0;
        end
    endtask

    task automatic check_words(input string tag);
        int errs = 0;
        for (int w = 0; w < WORDS; w++) begin
            if (!written[w] || mem[w] !== {bval(3*w), bval(3*w+1), bval(3*w+2)}) errs++;
        end
        chk(errs == 0, tag, errs, 0);
        chk(wr_cnt == WORDS, {tag, " count"}, wr_cnt, WORDS);
    endtask

    task automatic wait_run(input int maxc);
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (core_run === 1'b1) break;
        end
    endtask

    task automatic wait_rst_low(output int n);
        n = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (core_rst === 1'b1) n++;
            else break;
        end
    endtask

    task automatic warm_reset(input logic [3:0] code);
        ext_rst_n = 1'b0;
        mode_straps = code;
        repeat (3) @(negedge clk);
        clear_mon();
        ext_rst_n = 1'b1;
    endtask

    task automatic host_write(input logic [13:0] a);
        host_we = 1'b1; host_addr = a;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic run_mode(input int code);
        int n;
        logic [4:0] v;
        v = VEC[code];
        warm_reset(4'(code));
        wait_rst_low(n);
        chk(mem_full == v[2], $sformatf("R4 mem_full code %0d", code), mem_full, v[2]);
        chk(ack_pd_en == v[1], $sformatf("R4 ack_pd_en code %0d", code), ack_pd_en, v[1]);
        chk(start_ext == v[0], $sformatf("R9 start_ext code %0d", code), start_ext, v[0]);
        unique case (v[4:3])
            2'd0: begin
                repeat (3) @(negedge clk);
                chk(core_run && boot_done, $sformatf("R9 no-boot run code %0d", code), core_run, 1);
                chk(wr_cnt == 0, "R4 no-boot writes", wr_cnt, 0);
            end
            2'd1: begin
                repeat (20) @(negedge clk);
                chk(core_run == 1'b0, "R6 halted during byte boot", core_run, 0);
                wait_run(3000);
                chk(core_run == 1'b1, "R6 run after byte boot", core_run, 1);
                check_words($sformatf("R5 words code %0d", code));
            end
            default: begin
                repeat (20) @(negedge clk);
                chk(core_run == 1'b0, "R7 halted in host boot", core_run, 0);
                host_write(14'd7);
                repeat (4) @(negedge clk);
                chk(core_run == 1'b0, "R7 non-zero host write ignored", core_run, 0);
                host_write(14'd0);
                repeat (3) @(negedge clk);
                chk(core_run == 1'b1, "R7 run after host write to 0", core_run, 1);
            end
        endcase
        chk(start_addr == 14'd0, "R9 start_addr", int'(start_addr), 0);
    endtask

    initial begin
        int n;
        por_n = 1'b0; ext_rst_n = 1'b0; bus_req = 1'b0; host_we = 1'b0;
        host_addr = '0; mode_straps = 4'b0000; bm_valid = 1'b0; bm_data = '0;
        clear_mon();
        repeat (4) @(negedge clk);
        // R3 reset state
        chk(core_rst == 1'b1, "R3 core_rst in reset", core_rst, 1);
        chk(core_run == 1'b0 && boot_done == 1'b0, "R3 halted in reset", core_run, 0);
        por_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 cold lock wait, with bus held (R8) and strap change after capture (R10)
        bus_req = 1'b1;
        ext_rst_n = 1'b1;
        wait_rst_low(n);
        chk(n >= LOCK && n <= LOCK + 4, "R1 cold reset stretch", n, LOCK);
        mode_straps = 4'b0100;
        repeat (30) @(negedge clk);
        chk(bm_req == 1'b0, "R8 no byte request while bus claimed", bm_req, 0);
        chk(core_run == 1'b0, "R8 halted while bus claimed", core_run, 0);
        chk(mem_full == 1'b1, "R10 strap C change ignored", mem_full, 1);
        bus_req = 1'b0;
        wait_run(3000);
        chk(core_run == 1'b1, "R8 boot after bus free", core_run, 1);
        check_words("R5 cold byte boot");

        // R2 warm reset skips lock wait
        warm_reset(4'b0010);
        wait_rst_low(n);
        chk(n >= WARM && n <= WARM + 4, "R2 warm reset stretch", n, WARM);

        // strap table
        for (int c = 0; c < 16; c++) run_mode(c);

        // R11 reset in the middle of a byte boot
        warm_reset(4'b0000);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (wr_cnt >= 5) break;
        end
        ext_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(core_rst == 1'b1 && bm_req == 1'b0, "R11 boot aborted", bm_req, 0);
        chk(core_run == 1'b0, "R11 halted after abort", core_run, 0);
        clear_mon();
        ext_rst_n = 1'b1;
        wait_run(3000);
        chk(core_run == 1'b1, "R11 restart completes", core_run, 1);
        check_words("R11 R12 reload from word 0");

        finish_run();
    end
endmodule